// File: doc/BRIEF.md
# Configurable PLD Logic Macrocell

This block is one logic cell of a small programmable logic device. Five product terms arrive already computed by the AND array. The cell ORs any chosen subset of them with a sum passed in from a neighbouring cell and passes that total on to the next cell. An XOR stage then sets the polarity, and a storage element can act as a D, T, JK or SR flip-flop or as a transparent latch. The cell selects a registered or a combinational pad output, the feedback sent back to the routing, and the pad output enable.

Each product term has one fixed role when it is not used in the sum:
- `pt[0]` is the reset term.
- `pt[1]` is the preset term.
- `pt[2]` is the clock term, or the clock enable when the global clock is used.
- `pt[3]` is the separate data term, which is also K in JK mode and R in SR mode.
- `pt[4]` is the XOR term and the output-enable term.

A 20-bit configuration word holds the fields listed below. An external programming store supplies it.

Top module: `pld_macrocell`

## Requirements
- R1: `casc_out` equals the OR of `casc_in` and every `pt[i]` whose mask bit `cfg[i]` (bits 4:0) is 1. This holds whatever the output configuration is.
- R2: The XOR value is `casc_out` XOR a second operand. The second operand is chosen by `cfg[6:5]`: 00 gives 0, 01 gives 1, and 1x gives `pt[4]`. When `cfg[16]`=0 the XOR value drives `pad_out`.
- R3: Storage mode is `cfg[10:8]`: 000 D, 001 T, 010 JK, 011 SR, 100 latch, and any other code acts as D. In D mode the element loads its data on a rising edge of the selected clock. The data is the XOR value when `cfg[7]`=0 and `pt[3]` when `cfg[7]`=1.
- R4: In T mode the element inverts its state on a clock edge when the data is 1 and holds it when the data is 0.
- R5: In JK mode, J is the XOR value and K is `pt[3]`. On an edge, J=1 K=0 sets, J=0 K=1 clears, J=K=0 holds and J=K=1 toggles.
- R6: In SR mode, S is the XOR value and R is `pt[3]`. On an edge, S alone sets, R alone clears, and both 0 or both 1 hold.
- R7: In latch mode the element follows its data while the selected clock is high. It holds its value while the clock is low.
- R8: `cfg[11]`=0 selects `clk_g` as the clock and `cfg[11]`=1 selects `pt[2]`. Edges of the clock that is not selected have no effect.
- R9: With `cfg[12]`=1 and the global clock selected, `pt[2]` is a clock enable. While `pt[2]` is low, every `clk_g` edge is ignored.
- R10: Asynchronous reset is selected by `cfg[14:13]`. Bit 13 enables the reset from `clr_gn` low and bit 14 enables the reset from `pt[0]` high, so 00 means no reset and 11 means either source resets. Asynchronous preset is `pt[1]` when `cfg[15]`=1. Reset wins when reset and preset are both asserted.
- R11: `cfg[16]`=1 makes `pad_out` the stored value. `fb_out` is the stored value when `cfg[16]`=1 or `cfg[7]`=1, and otherwise it is the XOR value.
- R12: Output enable is selected by `cfg[19:17]`: 000 always on, 001 always off, 010 `!oe1_n`, 011 `!oe2_n`, 100 `pt[4]`. Any other code is off.
- R13: While `por_n` is low the stored value is 0, so a registered `pad_out` and `fb_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_g | input | 1 | Global clock |
| por_n | input | 1 | Power-on clear, active low |
| clr_gn | input | 1 | Global asynchronous clear, active low |
| oe1_n | input | 1 | Output-enable pin 1, active low |
| oe2_n | input | 1 | Output-enable pin 2, active low |
| pt | input | NPT (5) | Product terms from the AND array |
| casc_in | input | 1 | Cascade sum from the neighbouring cell |
| cfg | input | CFG_W (20) | Configuration word |
| casc_out | output | 1 | Local sum ORed with `casc_in` |
| pad_out | output | 1 | Pad data |
| pad_oe | output | 1 | Pad output enable |
| fb_out | output | 1 | Buried feedback to the routing |

## Verification
The bench drives the hold-versus-toggle cases of each flip-flop mode. A cell whose JK decode was swapped, or whose SR mode toggled when both inputs are 1, would give the wrong value at the second edge. The bench changes the latch data in both clock phases, which catches a latch implemented as an edge-triggered register. It raises reset and preset together, which shows any error in priority. It also pulses the clock-enable term and the product-term clock against the global clock, so a cell that ignores the enable or the clock selection would load data when it should hold.

// File: rtl/pld_macrocell.sv
module pld_macrocell #(
  parameter int NPT   = 5,
  parameter int CFG_W = NPT + 15
) (
  input  logic             clk_g,
  input  logic             por_n,
  input  logic             clr_gn,
  input  logic             oe1_n,
  input  logic             oe2_n,
  input  logic [NPT-1:0]   pt,
  input  logic             casc_in,
  input  logic [CFG_W-1:0] cfg,
  output logic             casc_out,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             fb_out
);
  localparam int PT_RST = 0;
  localparam int PT_SET = 1;
  localparam int PT_CLK = 2;
  localparam int PT_ALT = 3;
  localparam int PT_AUX = 4;
  localparam int F_XS = NPT;
  localparam int F_DS = NPT + 2;
  localparam int F_MD = NPT + 3;
  localparam int F_CK = NPT + 6;
  localparam int F_CE = NPT + 7;
  localparam int F_AR = NPT + 8;
  localparam int F_AP = NPT + 10;
  localparam int F_OR = NPT + 11;
  localparam int F_OE = NPT + 12;

  typedef enum logic [2:0] {
    M_D = 3'd0, M_T = 3'd1, M_JK = 3'd2, M_SR = 3'd3, M_LAT = 3'd4
  } mode_e;

  mode_e      mode;
  logic [1:0] xsel, ar_sel;
  logic [2:0] oe_sel;
  logic       xr, dsrc, clk_eff, en, arst, apre, nq, q, q_ff, q_lat;

  assign mode   = mode_e'(cfg[F_MD+2:F_MD]);
  assign xsel   = cfg[F_XS+1:F_XS];
  assign ar_sel = cfg[F_AR+1:F_AR];
  assign oe_sel = cfg[F_OE+2:F_OE];

  assign casc_out = (|(pt & cfg[NPT-1:0])) | casc_in;
  assign xr       = casc_out ^ (xsel[1] ? pt[PT_AUX] : xsel[0]);
  assign dsrc     = cfg[F_DS] ? pt[PT_ALT] : xr;

  assign clk_eff = cfg[F_CK] ? pt[PT_CLK] : clk_g;
  assign en      = cfg[F_CK] | ~cfg[F_CE] | pt[PT_CLK];
  assign arst    = ~por_n | (ar_sel[0] & ~clr_gn) | (ar_sel[1] & pt[PT_RST]);
  assign apre    = cfg[F_AP] & pt[PT_SET];

  always_comb begin
    case (mode)
      M_T:     nq = q_ff ^ dsrc;
      M_JK:    nq = (xr & ~q_ff) | (~pt[PT_ALT] & q_ff);
      M_SR:    nq = (xr ^ pt[PT_ALT]) ? xr : q_ff;
      default: nq = dsrc;
    endcase
  end

  always_ff @(posedge clk_eff or posedge arst or posedge apre) begin
    if (arst)      q_ff <= 1'b0;
    else if (apre) q_ff <= 1'b1;
    else if (en)   q_ff <= nq;
  end

  always_latch begin
    if (arst)                q_lat <= 1'b0;
    else if (apre)           q_lat <= 1'b1;
    else if (clk_eff && en)  q_lat <= dsrc;
  end

  assign q       = (mode == M_LAT) ? q_lat : q_ff;
  assign pad_out = cfg[F_OR] ? q : xr;
  assign fb_out  = (cfg[F_OR] | cfg[F_DS]) ? q : xr;

  always_comb begin
    case (oe_sel)
      3'd0:    pad_oe = 1'b1;
      3'd2:    pad_oe = ~oe1_n;
      3'd3:    pad_oe = ~oe2_n;
      3'd4:    pad_oe = pt[PT_AUX];
      default: pad_oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk #(
  parameter int NPT   = 5,
  parameter int CFG_W = NPT + 15
) (
  input logic             clk_g,
  input logic             por_n,
  input logic             clr_gn,
  input logic             oe1_n,
  input logic [NPT-1:0]   pt,
  input logic             casc_in,
  input logic [CFG_W-1:0] cfg,
  input logic             casc_out,
  input logic             pad_out,
  input logic             pad_oe
);
  localparam int B = NPT;

  logic no_async, hold_now, lat_open;
  assign no_async = !((cfg[B+8] && !clr_gn) || (cfg[B+9] && pt[0]) || (cfg[B+10] && pt[1]));
  assign hold_now = por_n && no_async && cfg[B+5:B+3] == 3'd0 && !cfg[B+6] && cfg[B+7]
                    && !pt[2] && cfg[B+11];
  assign lat_open = no_async && cfg[B+5:B+3] == 3'd4 && !cfg[B+6] && !cfg[B+7]
                    && cfg[B+2] && cfg[B+11];

  assert_casc_R1: assert property (@(posedge clk_g) disable iff (!por_n)
    casc_out == ((|(pt & cfg[NPT-1:0])) || casc_in));

  assert_comb_xor_R2: assert property (@(posedge clk_g) disable iff (!por_n)
    !cfg[B+11] |-> pad_out == (casc_out ^ (cfg[B+1] ? pt[4] : cfg[B])));

  assert_latch_open_R7: assert property (@(negedge clk_g) disable iff (!por_n)
    lat_open |-> pad_out == pt[3]);

  assert_ce_hold_R9: assert property (@(posedge clk_g) disable iff (!por_n)
    (hold_now && $past(hold_now) && $stable(cfg)) |-> pad_out == $past(pad_out));

  assert_gclr_R10: assert property (@(posedge clk_g) disable iff (!por_n)
    (cfg[B+8] && !clr_gn && cfg[B+11]) |-> !pad_out);

  assert_oe_off_R12: assert property (@(posedge clk_g) disable iff (!por_n)
    (cfg[B+14:B+12] == 3'd1) |-> !pad_oe);

  assert_oe_pin1_R12: assert property (@(posedge clk_g) disable iff (!por_n)
    (cfg[B+14:B+12] == 3'd2) |-> pad_oe == !oe1_n);

  assert_por_low_R13: assert property (@(posedge clk_g)
    (!por_n && cfg[B+11]) |-> !pad_out);
endmodule

bind pld_macrocell pld_macrocell_chk #(.NPT(NPT), .CFG_W(CFG_W)) u_chk (.*);

// File: tb/pld_macrocell_tb.sv
module pld_macrocell_tb;
  logic clk = 1'b0, por_n = 1'b0, clr_gn = 1'b1, oe1_n = 1'b1, oe2_n = 1'b1, casc_in = 1'b0;
  logic [4:0]  pt  = '0;
  logic [19:0] cfg = '0;
  logic casc_out, pad_out, pad_oe, fb_out;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  pld_macrocell u_dut (.clk_g(clk), .por_n, .clr_gn, .oe1_n, .oe2_n, .pt, .casc_in, .cfg,
                       .casc_out, .pad_out, .pad_oe, .fb_out);

  function automatic logic [19:0] mk(input logic [4:0] mask, input logic [1:0] xs,
      input logic ds, input logic [2:0] md, input logic ck, input logic ce,
      input logic [1:0] ar, input logic ap, input logic oreg, input logic [2:0] oe);
    return {oe, oreg, ap, ar, ce, ck, md, ds, xs, mask};
  endfunction

  task automatic check(input string tag, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #2; endtask
  task automatic por_pulse; por_n = 1'b0; #1; por_n = 1'b1; #1; endtask

  task automatic t_cascade;  // R1
    cfg = mk(5'b00101, 2'b00, 1'b0, 3'd0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 3'd1);
    pt = 5'b00100; casc_in = 1'b0; #1 check("R1 masked term", casc_out, 1'b1);
    pt = 5'b00010; #1 check("R1 unmasked term", casc_out, 1'b0);
    casc_in = 1'b1; #1 check("R1 cascade in", casc_out, 1'b1);
    casc_in = 1'b0; pt = '0; tick;
  endtask

  task automatic t_xor;  // R2
    cfg = mk(5'b00001, 2'b00, 1'b0, 3'd0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 3'd0);
    pt = 5'b00001; #1 check("R2 xor const0", pad_out, 1'b1);
    cfg = mk(5'b00001, 2'b01, 1'b0, 3'd0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 3'd0);
    #1 check("R2 xor const1", pad_out, 1'b0);
    cfg = mk(5'b00001, 2'b10, 1'b0, 3'd0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 3'd0);
    pt = 5'b10001; #1 check("R2 xor term high", pad_out, 1'b0);
    pt = 5'b00001; #1 check("R2 xor term low", pad_out, 1'b1);
    pt = '0; tick;
  endtask

  task automatic t_dmode;  // R3
    cfg = mk(5'b00001, 2'b00, 1'b0, 3'd0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 3'd0);
    pt = '0; por_pulse;
    pt[0] = 1'b1; #1 check("R3 no edge yet", pad_out, 1'b0);
    tick; check("R3 D loads xor", pad_out, 1'b1);
    cfg[7] = 1'b1; pt[3] = 1'b0; tick; check("R3 D loads separate term", pad_out, 1'b0);
    pt = '0;
  endtask

  task automatic t_tmode;  // R4
    cfg = mk(5'b00000, 2'b00, 1'b1, 3'd1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 3'd0);
    pt = 5'b01000; por_pulse;
    tick; check("R4 toggle 1", pad_out, 1'b1);
    tick; check("R4 toggle 2", pad_out, 1'b0);
    tick; check("R4 toggle 3", pad_out, 1'b1);
    pt[3] = 1'b0; tick; check("R4 hold", pad_out, 1'b1);
  endtask

  task automatic t_jk;  // R5
    cfg = mk(5'b00001, 2'b00, 1'b0, 3'd2, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 3'd0);
    pt = '0; por_pulse;
    pt = 5'b00001; tick; check("R5 J sets", pad_out, 1'b1);
    pt = 5'b00000; tick; check("R5 JK hold", pad_out, 1'b1);
    pt = 5'b01001; tick; check("R5 JK toggle low", pad_out, 1'b0);
    tick; check("R5 JK toggle high", pad_out, 1'b1);
    pt = 5'b01000; tick; check("R5 K clears", pad_out, 1'b0);
    pt = '0;
  endtask

  task automatic t_sr;  // R6
    cfg = mk(5'b00001, 2'b00, 1'b0, 3'd3, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 3'd0);
    pt = '0; por_pulse;
    pt = 5'b00001; tick; check("R6 S sets", pad_out, 1'b1);
    pt = 5'b01001; tick; check("R6 both hold high", pad_out, 1'b1);
    pt = 5'b01000; tick; check("R6 R clears", pad_out, 1'b0);
    pt = 5'b01001; tick; check("R6 both hold low", pad_out, 1'b0);
    pt = '0;
  endtask

  task automatic t_latch;  // R7
    cfg = mk(5'b00000, 2'b00, 1'b1, 3'd4, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 3'd0);
    pt = '0; por_pulse;
    pt[3] = 1'b1; #1 check("R7 transparent high", pad_out, 1'b1);
    @(negedge clk); #2 pt[3] = 1'b0; #1 check("R7 holds low phase", pad_out, 1'b1);
    tick; check("R7 opens again", pad_out, 1'b0);
  endtask

  task automatic t_clksel;  // R8
    cfg = mk(5'b00000, 2'b00, 1'b1, 3'd0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 3'd0);
    pt = 5'b01000; por_pulse;
    tick; tick; check("R8 global edges ignored", pad_out, 1'b0);
    pt[2] = 1'b1; #1 check("R8 term clock loads", pad_out, 1'b1);
    pt[2] = 1'b0; pt[3] = 1'b0; tick; check("R8 global still ignored", pad_out, 1'b1);
  endtask

  task automatic t_ce;  // R9
    cfg = mk(5'b00000, 2'b00, 1'b1, 3'd0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 3'd0);
    pt = 5'b01000; por_pulse;
    tick; tick; check("R9 enable low blocks", pad_out, 1'b0);
    pt[2] = 1'b1; tick; check("R9 enable high loads", pad_out, 1'b1);
    pt = '0;
  endtask

  task automatic t_async;  // R10
    cfg = mk(5'b00000, 2'b00, 1'b1, 3'd0, 1'b0, 1'b0, 2'b01, 1'b0, 1'b1, 3'd0);
    pt = 5'b01000; por_pulse; tick;
    clr_gn = 1'b0; #1 check("R10 global clear", pad_out, 1'b0);
    clr_gn = 1'b1; tick; check("R10 reload after clear", pad_out, 1'b1);
    cfg[14:13] = 2'b00; clr_gn = 1'b0; #1 check("R10 clear not selected", pad_out, 1'b1);
    clr_gn = 1'b1;
    cfg = mk(5'b00000, 2'b00, 1'b1, 3'd0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b1, 3'd0);
    pt = 5'b00001; #1 check("R10 term reset", pad_out, 1'b0);
    pt = 5'b00010; #1 check("R10 term preset", pad_out, 1'b1);
    pt = 5'b00011; #1 check("R10 reset beats preset", pad_out, 1'b0);
    pt = '0; tick;
  endtask

  task automatic t_outsel;  // R11
    cfg = mk(5'b00001, 2'b00, 1'b1, 3'd0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 3'd0);
    pt = 5'b00001; por_pulse; tick;
    check("R11 comb pad", pad_out, 1'b1);
    check("R11 buried register fb", fb_out, 1'b0);
    cfg[7] = 1'b0; #1 check("R11 comb fb", fb_out, 1'b1);
    cfg[16] = 1'b1; tick; pt[0] = 1'b0; #1
    check("R11 registered pad", pad_out, 1'b1);
    check("R11 registered fb", fb_out, 1'b1);
  endtask

  task automatic t_oe;  // R12
    cfg = mk(5'b00000, 2'b00, 1'b0, 3'd0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 3'd0);
    #1 check("R12 always on", pad_oe, 1'b1);
    cfg[19:17] = 3'd1; #1 check("R12 always off", pad_oe, 1'b0);
    cfg[19:17] = 3'd2; oe1_n = 1'b0; #1 check("R12 pin1 low", pad_oe, 1'b1);
    oe1_n = 1'b1; #1 check("R12 pin1 high", pad_oe, 1'b0);
    cfg[19:17] = 3'd3; oe2_n = 1'b0; #1 check("R12 pin2 low", pad_oe, 1'b1);
    oe2_n = 1'b1;
    cfg[19:17] = 3'd4; pt[4] = 1'b1; #1 check("R12 term high", pad_oe, 1'b1);
    pt[4] = 1'b0; #1 check("R12 term low", pad_oe, 1'b0);
    tick;
  endtask

  task automatic t_por;  // R13
    cfg = mk(5'b00000, 2'b00, 1'b1, 3'd0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 3'd0);
    pt = 5'b01000; tick;
    check("R13 loaded before clear", pad_out, 1'b1);
    por_n = 1'b0; #1
    check("R13 power-on clears pad", pad_out, 1'b0);
    check("R13 power-on clears fb", fb_out, 1'b0);
    por_n = 1'b1; pt = '0;
  endtask

  initial begin
    cfg = mk(5'b00000, 2'b00, 1'b0, 3'd0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 3'd0);
    tick; tick;
    check("R13 reset state pad", pad_out, 1'b0);
    check("R13 reset state fb", fb_out, 1'b0);
    por_n = 1'b1;
    t_cascade; t_xor; t_dmode; t_tmode; t_jk; t_sr; t_latch;
    t_clksel; t_ce; t_async; t_outsel; t_oe; t_por;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule